// File: doc/BRIEF.md
# Pipelined Multiply and Shift Datapath

This block is one 32-bit arithmetic slice that either multiplies two operands into a 64-bit product or moves the bits of operand A. A moving operation is a logical shift, an arithmetic shift or a rotate, in either direction. A single mode input chooses between multiply and move. Two more inputs pick the kind of move (shift or rotate) and its direction. The move distance comes from the low five bits of operand B. Each operand has its own sign control. That control decides how the multiplier reads the operand, and for A it also decides whether a right shift copies the sign bit into the vacated positions.

Every result goes through the same two registers. The first register, the capture stage, has its own enable, so an upstream stall can freeze it. The second register, the output stage, has a separate enable for a downstream stall. An asynchronous active-high reset clears both registers. All controls are sampled in the same cycle as the operands, so an operation is fully described by one input cycle.

Top module: `mulshift_unit`

## Requirements
- R1: With `sel_shift`=0 the computed value is the low 64 bits of the signed product of two 33-bit values. Each 33-bit value is the 32-bit operand with one extra top bit added. That bit is the operand's bit 31 when the operand's sign control is 1, and 0 when it is 0.
- R2: With `sel_shift`=1 the value being moved is `opa`. The distance is `opb[4:0]`, and the upper bits of `opb` have no effect.
- R3: A shift (`sel_rotate`=0) to the right (`go_right`=1) with `a_is_signed`=0 fills the vacated upper bits with 0.
- R4: A right shift with `a_is_signed`=1 fills the vacated upper bits with `opa[31]`.
- R5: A left shift (`go_right`=0) always fills the vacated low bits with 0, whatever the value of `a_is_signed`.
- R6: With `sel_rotate`=1, bits that leave one end of the 32-bit word re-enter at the other end, for any distance from 0 to 31 in either direction. Neither sign control changes the result.
- R7: In move mode, bits 63..32 of the computed value are 0.
- R8: The capture stage loads the computed value on a rising edge when `load_en`=1 and keeps its contents when `load_en`=0.
- R9: The output stage (`result`) loads the capture stage on a rising edge when `drain_en`=1 and keeps its value when `drain_en`=0.
- R10: While `arst`=1 both stages are 0. The clear takes effect at once, without waiting for a clock edge.
- R11: The controls and operands of one cycle make up one operation. With both enables high, its result appears on `result` after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| arst | input | 1 | Asynchronous reset, active high, clears both stages |
| load_en | input | 1 | Enable of the capture stage |
| drain_en | input | 1 | Enable of the output stage |
| a_is_signed | input | 1 | Treat `opa` as signed; selects arithmetic right shift |
| b_is_signed | input | 1 | Treat `opb` as signed in multiply mode |
| sel_shift | input | 1 | 1 = shift/rotate, 0 = multiply |
| go_right | input | 1 | Move direction: 1 = right, 0 = left |
| sel_rotate | input | 1 | 1 = rotate, 0 = shift |
| opa | input | 32 | Operand A, the multiplicand or the word being moved |
| opb | input | 32 | Operand B, the multiplier or the move distance in bits 4..0 |
| result | output | 64 | Output stage contents |

## Verification
With both enables held high, an operation presented in one cycle is due on `result` after the second rising edge that follows. The bench samples at the falling edge two edges after it drives the inputs, and the latency check also confirms that the old value is still present one edge earlier. Under random enables the result is due only once the capture stage has loaded the operation and the output stage has then loaded it in turn. The bench keeps a reference pair of registers with the same enables and compares against it at every falling edge, so each value is checked exactly in the cycle the two stages make it visible.

// File: rtl/mulshift_unit.sv
module mulshift_unit #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               arst,
  input  logic               load_en,
  input  logic               drain_en,
  input  logic               a_is_signed,
  input  logic               b_is_signed,
  input  logic               sel_shift,
  input  logic               go_right,
  input  logic               sel_rotate,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  output logic [2*WIDTH-1:0] result
);
  localparam int AW = $clog2(WIDTH);
  localparam int RW = 2 * WIDTH;
  localparam int PW = RW + 2;

  logic [WIDTH:0]    ext_a, ext_b;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]     amt;
  logic              fill;
  logic [RW-1:0]     sr_wide, dbl, rot_r, rot_l;
  logic [WIDTH-1:0]  shl, moved;
  logic [RW-1:0]     nxt, s1;
  logic              unused_bits;

  assign ext_a = {a_is_signed & opa[WIDTH-1], opa};
  assign ext_b = {b_is_signed & opb[WIDTH-1], opb};
  assign prod  = $signed({{(WIDTH+1){ext_a[WIDTH]}}, ext_a})
               * $signed({{(WIDTH+1){ext_b[WIDTH]}}, ext_b});

  assign amt     = opb[AW-1:0];
  assign fill    = a_is_signed & opa[WIDTH-1];
  assign sr_wide = {{WIDTH{fill}}, opa} >> amt;
  assign shl     = opa << amt;
  assign dbl     = {opa, opa};
  assign rot_r   = dbl >> amt;
  assign rot_l   = dbl << amt;

  always_comb begin
    if (sel_rotate) moved = go_right ? rot_r[WIDTH-1:0] : rot_l[RW-1:WIDTH];
    else            moved = go_right ? sr_wide[WIDTH-1:0] : shl;
  end

  assign nxt = sel_shift ? {{WIDTH{1'b0}}, moved} : prod[RW-1:0];

  assign unused_bits = ^{opb[WIDTH-1:AW], prod[PW-1:RW], sr_wide[RW-1:WIDTH],
                         rot_r[RW-1:WIDTH], rot_l[WIDTH-1:0]};

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         s1 <= '0;
    else if (load_en) s1 <= nxt;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          result <= '0;
    else if (drain_en) result <= s1;
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk) arst |-> (result == '0 && s1 == '0));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (arst)
    !drain_en |=> $stable(result));

  // R9
  out_copy_chk: assert property (@(posedge clk) disable iff (arst)
    drain_en |=> result == $past(s1));

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (arst)
    !load_en |=> $stable(s1));

  // R7
  move_upper_zero_chk: assert property (@(posedge clk) disable iff (arst)
    (load_en && sel_shift) |=> s1[RW-1:WIDTH] == '0);

  // R5
  left_fill_chk: assert property (@(posedge clk) disable iff (arst)
    (load_en && sel_shift && !sel_rotate && !go_right && amt != '0) |=> s1[0] == 1'b0);

  // R4
  arith_fill_chk: assert property (@(posedge clk) disable iff (arst)
    (load_en && sel_shift && !sel_rotate && go_right && a_is_signed && opa[WIDTH-1])
      |=> s1[WIDTH-1] == 1'b1);

  // R3
  logic_fill_chk: assert property (@(posedge clk) disable iff (arst)
    (load_en && sel_shift && !sel_rotate && go_right && !a_is_signed && amt != '0)
      |=> s1[WIDTH-1] == 1'b0);
endmodule

// File: tb/sim_mulshift_unit.sv
module sim_mulshift_unit;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic arst, load_en, drain_en, a_is_signed, b_is_signed;
  logic sel_shift, go_right, sel_rotate;
  logic [31:0] opa, opb;
  logic [63:0] result;
  logic [63:0] m1, m2;
  int total = 0;
  int bad = 0;
  bit done = 0;

  mulshift_unit u0 (
    .clk(clk), .arst(arst), .load_en(load_en), .drain_en(drain_en),
    .a_is_signed(a_is_signed), .b_is_signed(b_is_signed),
    .sel_shift(sel_shift), .go_right(go_right), .sel_rotate(sel_rotate),
    .opa(opa), .opb(opb), .result(result)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] expect_op(logic [31:0] a, logic [31:0] b,
      logic sa, logic sb, logic sh, logic rt, logic rot);
    logic signed [65:0] xa, xb, p;
    logic [31:0] r;
    int n;
    if (!sh) begin
      xa = sa ? {{34{a[31]}}, a} : {34'b0, a};
      xb = sb ? {{34{b[31]}}, b} : {34'b0, b};
      p  = xa * xb;
      return p[63:0];
    end
    n = int'(b[4:0]);
    for (int i = 0; i < 32; i++) begin
      if (rot) r[i] = rt ? a[(i + n) % 32] : a[(i - n + 32) % 32];
      else if (rt) r[i] = (i + n < 32) ? a[i + n] : (sa & a[31]);
      else r[i] = (i >= n) ? a[i - n] : 1'b0;
    end
    return {32'b0, r};
  endfunction

  always @(posedge clk or posedge arst) begin
    if (arst) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      if (load_en) m1 <= expect_op(opa, opb, a_is_signed, b_is_signed, sel_shift, go_right, sel_rotate);
      if (drain_en) m2 <= m1;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic sa, logic sb,
                       logic sh, logic rt, logic rot);
    opa = a; opb = b; a_is_signed = sa; b_is_signed = sb;
    sel_shift = sh; go_right = rt; sel_rotate = rot;
  endtask

  task automatic run_op(string tag, logic [31:0] a, logic [31:0] b, logic sa, logic sb,
                        logic sh, logic rt, logic rot, logic [63:0] exp);
    @(negedge clk);
    load_en = 1; drain_en = 1;
    drive(a, b, sa, sb, sh, rt, rot);
    @(negedge clk);
    @(negedge clk);
    check(tag, result, exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'd1234;
    r = $urandom(seed);
    arst = 1; load_en = 0; drain_en = 0;
    drive(32'h0, 32'h0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R10 during reset", result, 64'h0);
    arst = 0;
    @(negedge clk);
    check("R10 after release", result, 64'h0);

    run_op("R1 signed*signed", 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 1, 0, 0, 0, 64'h1);
    run_op("R1 unsigned*unsigned", 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 64'hFFFFFFFE00000001);
    run_op("R1 signed*unsigned", 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, 0, 0, 0, 64'hFFFFFFFF00000001);
    run_op("R1 signed*small", 32'hFFFFFFFF, 32'h2, 1, 0, 0, 0, 0, 64'hFFFFFFFFFFFFFFFE);
    run_op("R3 logical right", 32'h80000000, 32'h4, 0, 0, 1, 1, 0, 64'h08000000);
    run_op("R4 arithmetic right", 32'h80000000, 32'h4, 1, 0, 1, 1, 0, 64'hF8000000);
    run_op("R5 left ignores sign", 32'h80000001, 32'h1, 1, 1, 1, 0, 0, 64'h2);
    run_op("R2 amount low five bits", 32'h00000003, 32'hFFFFFFE1, 0, 0, 1, 0, 0, 64'h6);
    run_op("R6 rotate right wraps", 32'h00000001, 32'h1, 1, 1, 1, 1, 1, 64'h80000000);
    run_op("R6 rotate left wraps", 32'h80000001, 32'h1F, 1, 0, 1, 0, 1, 64'hC0000000);
    run_op("R7 upper half zero", 32'hFFFFFFFF, 32'h0, 1, 1, 1, 1, 0, 64'h00000000FFFFFFFF);

    // R11: new operation not visible after one edge, visible after two
    @(negedge clk);
    drive(32'h10, 32'h10, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R11 one edge old value", result, 64'h00000000FFFFFFFF);
    @(negedge clk);
    check("R11 two edges new value", result, 64'h100);

    // R9 hold, R8 hold
    load_en = 1; drain_en = 0;
    drive(32'h7, 32'h3, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    check("R9 output holds", result, 64'h100);
    load_en = 0; drain_en = 1;
    drive(32'hDEAD, 32'hBEEF, 1, 1, 0, 0, 0);
    @(negedge clk);
    check("R9 output copies stage", result, 64'h15);
    @(negedge clk);
    check("R8 capture holds", result, 64'h15);

    // R10 asynchronous clear mid-cycle
    #1 arst = 1;
    #1 check("R10 async clear", result, 64'h0);
    @(negedge clk);
    arst = 0;

    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      check("R1-model random cycle", result, m2);
      r = $urandom;
      load_en = (r[2:0] != 0);
      drain_en = (r[5:3] != 0);
      a_is_signed = r[6];
      b_is_signed = r[7];
      sel_shift = r[8];
      go_right = r[9];
      sel_rotate = r[10];
      opa = $urandom;
      opb = (r[13:11] == 0) ? 32'hFFFFFFFF : $urandom;
      if (r[16:14] == 0) opa = {r[17], 31'h0};
    end
    @(negedge clk);
    check("R11 final", result, m2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule